// File: doc/BRIEF.md
# Maskable Edge/Level Interrupt Collector

This block gathers sixteen condition inputs, arranged as two groups of eight, and merges them into one active-low interrupt line. Each input has its own enable bit and its own 2-bit trigger code. The code chooses whether the input fires when the condition appears, when it goes away, or for as long as it lasts. An event from an enabled input sets a sticky bit in that group's status register. Any set status bit pulls the interrupt line low.

Software reaches every register through a small port with an address, a write strobe, a read strobe and data. Reads are combinational in the cycle of the read strobe. Reading a status register returns its bits and clears them at the next clock edge. An event that lands in that same cycle stays set. The condition inputs are synchronous to the block clock. Edges are found by comparing each input with its value one cycle earlier.

Top module: `irq_gate`

## Requirements
- R1: When input i of a group is enabled and its trigger fires, status bit i of that group is set after the next clock edge, and irq_n is low from that edge on.
- R2: When the enable bit of an input is 0, its events set no status bit and do not pull irq_n low. Writing 0 to an enable bit clears the matching status bit at the edge after the write.
- R3: Condition bit i, enable bit i, trigger-code bit i and status bit i all refer to the same input. An event in one group never sets a status bit in the other group.
- R4: The trigger code of input i is {bit i of the code-high register, bit i of the code-low register}. 00 fires on a 0-to-1 change, 01 fires on a 1-to-0 change, 10 fires in every cycle the condition is 1, and 11 behaves like 00.
- R5: In code 10 the status bit reads 1 again after a read for as long as the condition stays 1. After the condition drops, the bit stays set until the next read.
- R6: After reset every register reads 00h and irq_n is high.
- R7: Reading status address 7 (group A) or 8 (group B) returns the current bits and clears them at that edge. A trigger that fires in the same cycle as the read still leaves its bit set.
- R8: Register map: 9/10/11 are group A enable, code-high and code-low; 12/13/14 are the same three for group B. All six read back what was written. Writes to 7 and 8 are ignored, and any other address reads 00h.
- R9: irq_n stays low while any status bit of either group is set. It goes high only once both groups are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_a | input | 8 | Group A condition inputs |
| cond_b | input | 8 | Group B condition inputs |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears a status register that is read |
| reg_rdata | output | 8 | Read data, valid in the cycle of the address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps every bit of both groups through all four trigger codes, enabled and disabled. It raises and then drops the condition, reads the status after each step, and reads it a second time to check clearing. A design that swapped the code halves would mix up falling and level behaviour, and one that ignored code 11 would never fire in that case. A design that cleared level bits for good on a read would lose a condition that is still present. Directed cases cover an event that fires in the same cycle as a status read, which a naive clear would drop, and the release of irq_n only after both groups are read. They also cover a status bit that must disappear when its enable is withdrawn.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cond_a,
  input  logic [W-1:0]  cond_b,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          reg_rd,
  output logic [W-1:0]  reg_rdata,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_STA = AW'(7);
  localparam logic [AW-1:0] A_STB = AW'(8);
  localparam logic [AW-1:0] A_MKA = AW'(9);
  localparam logic [AW-1:0] A_HIA = AW'(10);
  localparam logic [AW-1:0] A_LOA = AW'(11);
  localparam logic [AW-1:0] A_MKB = AW'(12);
  localparam logic [AW-1:0] A_HIB = AW'(13);
  localparam logic [AW-1:0] A_LOB = AW'(14);

  logic [W-1:0] mk_a, hi_a, lo_a, st_a, pv_a;
  logic [W-1:0] mk_b, hi_b, lo_b, st_b, pv_b;
  logic [W-1:0] ev_a, ev_b;
  logic         rd_a, rd_b;

  function automatic logic [W-1:0] trig(input logic [W-1:0] cur, input logic [W-1:0] prv,
                                        input logic [W-1:0] hi, input logic [W-1:0] lo);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      case ({hi[i], lo[i]})
        2'b01:   r[i] = prv[i] & ~cur[i];
        2'b10:   r[i] = cur[i];
        default: r[i] = cur[i] & ~prv[i];
      endcase
    end
    return r;
  endfunction

  assign ev_a = trig(cond_a, pv_a, hi_a, lo_a) & mk_a;
  assign ev_b = trig(cond_b, pv_b, hi_b, lo_b) & mk_b;
  assign rd_a = reg_rd && (reg_addr == A_STA);
  assign rd_b = reg_rd && (reg_addr == A_STB);
  assign irq_n = ~(|st_a | |st_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_a <= '0; hi_a <= '0; lo_a <= '0; st_a <= '0; pv_a <= '0;
      mk_b <= '0; hi_b <= '0; lo_b <= '0; st_b <= '0; pv_b <= '0;
    end else begin
      pv_a <= cond_a;
      pv_b <= cond_b;
      st_a <= ((rd_a ? '0 : st_a) | ev_a) & mk_a;
      st_b <= ((rd_b ? '0 : st_b) | ev_b) & mk_b;
      if (reg_wr) begin
        case (reg_addr)
          A_MKA:   mk_a <= reg_wdata;
          A_HIA:   hi_a <= reg_wdata;
          A_LOA:   lo_a <= reg_wdata;
          A_MKB:   mk_b <= reg_wdata;
          A_HIB:   hi_b <= reg_wdata;
          A_LOB:   lo_b <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STA:   reg_rdata = st_a;
      A_STB:   reg_rdata = st_b;
      A_MKA:   reg_rdata = mk_a;
      A_HIA:   reg_rdata = hi_a;
      A_LOA:   reg_rdata = lo_a;
      A_MKB:   reg_rdata = mk_b;
      A_HIB:   reg_rdata = hi_b;
      A_LOB:   reg_rdata = lo_b;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  cond_a,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          irq_n,
  input logic [W-1:0]  mk_a,
  input logic [W-1:0]  mk_b,
  input logic [W-1:0]  hi_a,
  input logic [W-1:0]  lo_a,
  input logic [W-1:0]  st_a,
  input logic [W-1:0]  pv_a
);
  p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_a[0] && !hi_a[0] && !lo_a[0] && cond_a[0] && !pv_a[0]) |=> (st_a[0] && !irq_n));

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && mk_a == '0 && mk_b == '0) |=> irq_n);

  p_fall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_a[0] && !hi_a[0] && lo_a[0] && !cond_a[0] && pv_a[0]) |=> st_a[0]);

  p_level_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_a[0] && hi_a[0] && !lo_a[0] && cond_a[0]) |=> st_a[0]);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(7) && hi_a == '0 && lo_a == '0 && cond_a == pv_a) |=> (st_a == '0));
endmodule

bind irq_gate irq_gate_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_a(cond_a), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .irq_n(irq_n), .mk_a(mk_a), .mk_b(mk_b), .hi_a(hi_a), .lo_a(lo_a),
  .st_a(st_a), .pv_a(pv_a)
);

// File: tb/tb_irq_gate.sv
module tb_irq_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] cond_a = 0, cond_b = 0;
  logic [3:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_n;
  int tests = 0, fails = 0;

  irq_gate dut (.clk(clk), .rst_n(rst_n), .cond_a(cond_a), .cond_b(cond_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 4'(a); reg_rd = 1;
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic setc(input int g, input int v);
    if (g == 0) cond_a = 8'(v); else cond_b = 8'(v);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 irq_n after reset", int'(irq_n), 1);
    for (int a = 7; a <= 14; a++) begin
      rd(a, d);
      chk("R6 register after reset", d, 0);
    end

    for (int g = 0; g < 2; g++)
      for (int b = 0; b < 8; b++)
        for (int m = 0; m < 4; m++)
          for (int en = 0; en < 2; en++) begin
            int bit_v, e1, e2, e3;
            string tag;
            tag = en ? "R4" : "R2";
            bit_v = en ? (1 << b) : 0;
            wr(9 + 3*g, bit_v);
            wr(10 + 3*g, (m >> 1) ? (1 << b) : 0);
            wr(11 + 3*g, (m & 1) ? (1 << b) : 0);
            rd(7 + g, d);
            e1 = (m != 1) ? bit_v : 0;
            e2 = (m == 2) ? bit_v : 0;
            e3 = (m == 1 || m == 2) ? bit_v : 0;
            setc(g, 1 << b);
            chk("R1 irq_n after arrival", int'(irq_n), (e1 == 0) ? 1 : 0);
            rd(7 + g, d);
            chk({tag, " status after arrival"}, d, e1);
            rd(8 - g, d);
            chk("R3 other group untouched", d, 0);
            rd(7 + g, d);
            chk({tag, " R5 status after second read"}, d, e2);
            setc(g, 0);
            rd(7 + g, d);
            chk({tag, " status after removal"}, d, e3);
            rd(7 + g, d);
            chk("R7 status cleared by read", d, 0);
            chk("R9 irq_n released", int'(irq_n), 1);
          end

    wr(9, 8'h03); wr(10, 0); wr(11, 0);
    setc(0, 8'h01);
    reg_addr = 4'd7; reg_rd = 1; cond_a = 8'h03;
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 0;
    chk("R7 read returns older event", d, 1);
    rd(7, d);
    chk("R7 same-cycle event kept", d, 2);
    setc(0, 0);

    wr(12, 8'h80); wr(13, 0); wr(14, 0);
    setc(0, 8'h02); setc(1, 8'h80);
    rd(7, d);
    chk("R9 irq_n low with group B pending", int'(irq_n), 0);
    rd(8, d);
    chk("R9 group B status", d, 8'h80);
    chk("R9 irq_n high after both read", int'(irq_n), 1);
    setc(0, 0); setc(1, 0);

    setc(0, 8'h01);
    chk("R2 irq_n low before unmask", int'(irq_n), 0);
    wr(9, 0);
    @(negedge clk);
    chk("R2 irq_n high after disable", int'(irq_n), 1);
    rd(7, d);
    chk("R2 status dropped after disable", d, 0);
    setc(0, 0);

    for (int a = 9; a <= 14; a++) begin
      wr(a, 8'hA0 + a);
      rd(a, d);
      chk("R8 readback", d, 8'hA0 + a);
    end
    wr(7, 8'hFF);
    rd(7, d);
    chk("R8 status write ignored", d, 0);
    wr(8, 8'hFF);
    rd(8, d);
    chk("R8 status B write ignored", d, 0);
    wr(0, 8'h55);
    rd(0, d);
    chk("R8 unmapped reads zero", d, 0);
    rd(15, d);
    chk("R8 unmapped 15 reads zero", d, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule